// File: doc/BRIEF.md
# Dual-Device ATA Task-File Interface

This block sits between a host register port and up to two ATA devices that share one cable. For each device that is marked present it keeps a full task file: the 8-bit control, addressing and status registers and a 16-bit data port that drains a sector buffer word by word. A host write is broadcast to every present device. A host read is answered by exactly one device, chosen from the presence pattern and the device-select bit of the device/head register.

Command decoding and buffer storage stay outside. Outside logic loads each device's status and error registers and arms a buffer transfer with a word count. The block presents the current buffer pointer and takes the addressed word back in the same cycle. It reports which devices accepted a command, flags commands issued while a device is busy or mid-transfer, and forwards device-control and data-port writes.

Top module: `ata_tf_host`

## Requirements
- R1: Register addresses are 0 data, 1 error (read) / features (write), 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 device/head, 7 status (read) / command (write), 14 alternate status (read) / device control (write). A write updates that register in every present device and leaves absent devices unchanged. A data-port write pulses `dwr_o` one cycle later with the 16-bit word on `dwdata_o`. `feat_o` shows the features register of device 1 in bits 15:8 and of device 0 in bits 7:0.
- R2: Any read or write while `dev_present_i` is 0 pulses `no_dev_o` one cycle later, and a read then returns 0.
- R3: With both devices present, device 1 answers reads when bit 4 of its device/head register is 1, and device 0 answers otherwise. With one device present, that device answers.
- R4: A read of status (7) or alternate status (14) returns 0 when bit 4 of the answering device's device/head register differs from that device's ID (0 or 1). Otherwise it returns the status byte, with bit 7 BSY and bit 3 DRQ.
- R5: A data-port read while the answering device has DRQ clear returns 0 and leaves its pointer unchanged.
- R6: Loading a buffer with count N sets the pointer to 0 and sets DRQ when N is nonzero. Each data-port read while DRQ is set returns `buf_rdata_i` for the pointer shown on `buf_ptr_o`, then advances the pointer and decrements the count. DRQ clears after the last word. A status load writes every status bit except DRQ, and it clears DRQ when its bit 3 is 0.
- R7: A command write pulses `cmd_exec_o[d]` one cycle later, with the code on `cmd_o`, only for present devices whose ID equals device/head bit 4. Code 0x90 (execute diagnostics) pulses every present device.
- R8: A command write to a present device whose BSY or DRQ is set pulses `proto_warn_o[d]` one cycle later, unless the code is 0x08 (device reset).
- R9: A device-control write pulses `ctrl_wr_o[d]` for each present device one cycle later, with the value on `ctrl_o`.
- R10: A device/head write stores only bit 4 and bits 3:0. Bits 7:5 always read as 101.
- R11: Read data is registered. `rvalid_o` rises one cycle after `rd_i`, and `rdata_o` holds the result in that cycle.
- R12: After reset every register is 0, device/head reads 0xA0, DRQ is clear and no pulse output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_present_i | input | 2 | Presence of device 1 and device 0 |
| addr_i | input | 4 | Task-file register address |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| no_dev_o | output | 1 | Access with no device present |
| stat_wr_i | input | 2 | Per-device status/error load |
| stat_i | input | 8 | Status value to load |
| err_i | input | 8 | Error value to load |
| buf_load_i | input | 2 | Per-device buffer arm |
| buf_cnt_i | input | CNT_W | Word count for buffer arm |
| buf_ptr_o | output | PTR_W | Pointer of answering device |
| buf_rdata_i | input | 16 | Buffer word at buf_ptr_o |
| dwr_o | output | 1 | Data-port write pulse |
| dwdata_o | output | 16 | Data-port write word |
| cmd_exec_o | output | 2 | Per-device command accept pulse |
| cmd_o | output | 8 | Last command code |
| feat_o | output | 16 | Features registers of both devices |
| proto_warn_o | output | 2 | Command issued while busy |
| ctrl_wr_o | output | 2 | Per-device control write pulse |
| ctrl_o | output | 8 | Last device-control value |

## Verification
A wrong selection decision shows on the first read after the device/head write: status comes back zero, or the other device's value appears on `rdata_o`. A corrupted pointer or word count shows on `buf_ptr_o` in the same cycle and on the next data-port word one cycle later. DRQ dropping early or late shows as a zero word, or a nonzero word read after the last one. Errors in the command gate or busy flag show on the per-device pulses one cycle after the command write. A reference model compares every output on every clock, so each of these faults is caught within a cycle or two of the access that exposes it.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [3:0] RA_DATA    = 4'h0;
  localparam logic [3:0] RA_ERRFEAT = 4'h1;
  localparam logic [3:0] RA_SCNT    = 4'h2;
  localparam logic [3:0] RA_SNUM    = 4'h3;
  localparam logic [3:0] RA_CYLL    = 4'h4;
  localparam logic [3:0] RA_CYLH    = 4'h5;
  localparam logic [3:0] RA_DEVHD   = 4'h6;
  localparam logic [3:0] RA_STATCMD = 4'h7;
  localparam logic [3:0] RA_ALTCTL  = 4'hE;

  localparam int ST_BSY = 7;
  localparam int ST_DRQ = 3;
  localparam int DH_SEL = 4;

  localparam logic [7:0] OP_DIAG = 8'h90;
  localparam logic [7:0] OP_DRST = 8'h08;
  localparam logic [2:0] DH_FIXED = 3'b101;
endpackage

// File: rtl/ata_tf_sel.sv
module ata_tf_sel (
  input  logic [1:0] present_i,
  input  logic       dh1_sel_i,
  output logic       any_o,
  output logic       ans_o
);
  always_comb begin
    any_o = |present_i;
    // lone device 1 answers; with both, device 1 answers only when selected
    ans_o = present_i[1] & (~present_i[0] | dh1_sel_i);
  end
endmodule

// File: rtl/ata_tf_dev.sv
module ata_tf_dev
  import ata_tf_pkg::*;
#(
  parameter int DEV_ID = 0,
  parameter int CNT_W  = 9,
  parameter int PTR_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             present_i,
  input  logic             wr_i,
  input  logic             rd_data_i,
  input  logic [3:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             stat_wr_i,
  input  logic [7:0]       stat_i,
  input  logic [7:0]       err_i,
  input  logic             buf_load_i,
  input  logic [CNT_W-1:0] buf_cnt_i,
  output logic [7:0]       dh_o,
  output logic [7:0]       feat_o,
  output logic [15:0]      rword_o,
  output logic             drq_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             cmd_exec_o,
  output logic             warn_o,
  output logic             ctrl_wr_o
);
  localparam logic ID_BIT = (DEV_ID != 0);

  logic [7:0]       scnt_q, snum_q, cyll_q, cylh_q, err_q, feat_q;
  logic [4:0]       dh_q;
  logic [6:0]       stat_q;   // status without DRQ
  logic             drq_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] wcnt_q;
  logic [7:0]       status;
  logic             host_wr;

  assign host_wr = wr_i & present_i;
  assign status  = {stat_q[6:3], drq_q, stat_q[2:0]};
  assign dh_o    = {DH_FIXED, dh_q};
  assign feat_o  = feat_q;
  assign drq_o   = drq_q;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_q     <= '0;
      snum_q     <= '0;
      cyll_q     <= '0;
      cylh_q     <= '0;
      err_q      <= '0;
      feat_q     <= '0;
      dh_q       <= '0;
      stat_q     <= '0;
      drq_q      <= 1'b0;
      ptr_q      <= '0;
      wcnt_q     <= '0;
      cmd_exec_o <= 1'b0;
      warn_o     <= 1'b0;
      ctrl_wr_o  <= 1'b0;
    end else begin
      cmd_exec_o <= 1'b0;
      warn_o     <= 1'b0;
      ctrl_wr_o  <= 1'b0;
      if (host_wr) begin
        unique case (addr_i)
          RA_ERRFEAT: feat_q <= wdata_i;
          RA_SCNT:    scnt_q <= wdata_i;
          RA_SNUM:    snum_q <= wdata_i;
          RA_CYLL:    cyll_q <= wdata_i;
          RA_CYLH:    cylh_q <= wdata_i;
          RA_DEVHD:   dh_q   <= wdata_i[4:0];
          RA_STATCMD: begin
            warn_o     <= (status[ST_BSY] | drq_q) && (wdata_i != OP_DRST);
            cmd_exec_o <= (dh_q[DH_SEL] == ID_BIT) || (wdata_i == OP_DIAG);
          end
          RA_ALTCTL:  ctrl_wr_o <= 1'b1;
          default: ;
        endcase
      end
      if (buf_load_i) begin
        wcnt_q <= buf_cnt_i;
        ptr_q  <= '0;
        drq_q  <= (buf_cnt_i != '0);
      end else if (rd_data_i && drq_q) begin
        ptr_q  <= ptr_q + 1'b1;
        wcnt_q <= wcnt_q - 1'b1;
        if (wcnt_q == CNT_W'(1)) drq_q <= 1'b0;
      end
      if (stat_wr_i) begin
        stat_q <= {stat_i[7:4], stat_i[2:0]};
        err_q  <= err_i;
        if (!stat_i[ST_DRQ]) drq_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      RA_ERRFEAT: rword_o = {8'h00, err_q};
      RA_SCNT:    rword_o = {8'h00, scnt_q};
      RA_SNUM:    rword_o = {8'h00, snum_q};
      RA_CYLL:    rword_o = {8'h00, cyll_q};
      RA_CYLH:    rword_o = {8'h00, cylh_q};
      RA_DEVHD:   rword_o = {8'h00, dh_o};
      RA_STATCMD,
      RA_ALTCTL:  rword_o = (dh_q[DH_SEL] == ID_BIT) ? {8'h00, status} : 16'h0000;
      default:    rword_o = 16'h0000;
    endcase
  end

  p_drq_has_words_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_q |-> (wcnt_q != '0));

  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && drq_q && !buf_load_i) |=> (ptr_q == $past(ptr_q) + 1'b1));

  p_exec_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr && addr_i == RA_STATCMD && wdata_i != OP_DIAG && dh_q[DH_SEL] != ID_BIT)
      |=> !cmd_exec_o);

  p_reset_no_warn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr && addr_i == RA_STATCMD && wdata_i == OP_DRST) |=> !warn_o);

  p_absent_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |=> (!cmd_exec_o && !ctrl_wr_o && !warn_o));
endmodule

// File: rtl/ata_tf_host.sv
module ata_tf_host
  import ata_tf_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       dev_present_i,
  input  logic [3:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [15:0]      wdata_i,
  output logic [15:0]      rdata_o,
  output logic             rvalid_o,
  output logic             no_dev_o,
  input  logic [1:0]       stat_wr_i,
  input  logic [7:0]       stat_i,
  input  logic [7:0]       err_i,
  input  logic [1:0]       buf_load_i,
  input  logic [CNT_W-1:0] buf_cnt_i,
  output logic [PTR_W-1:0] buf_ptr_o,
  input  logic [15:0]      buf_rdata_i,
  output logic             dwr_o,
  output logic [15:0]      dwdata_o,
  output logic [1:0]       cmd_exec_o,
  output logic [7:0]       cmd_o,
  output logic [15:0]      feat_o,
  output logic [1:0]       proto_warn_o,
  output logic [1:0]       ctrl_wr_o,
  output logic [7:0]       ctrl_o
);
  localparam int NDEV = 2;

  logic [7:0]       dh_w    [NDEV];
  logic [15:0]      rword_w [NDEV];
  logic [PTR_W-1:0] ptr_w   [NDEV];
  logic [NDEV-1:0]  drq_w;
  logic [NDEV-1:0]  rd_data_w;
  logic             any_dev, ans;
  logic             data_rd;

  ata_tf_sel u_sel (
    .present_i (dev_present_i),
    .dh1_sel_i (dh_w[1][DH_SEL]),
    .any_o     (any_dev),
    .ans_o     (ans)
  );

  assign data_rd = rd_i && any_dev && (addr_i == RA_DATA);

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    assign rd_data_w[g] = data_rd && (ans == 1'(g));

    ata_tf_dev #(
      .DEV_ID (g),
      .CNT_W  (CNT_W),
      .PTR_W  (PTR_W)
    ) u_dev (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .present_i  (dev_present_i[g]),
      .wr_i       (wr_i),
      .rd_data_i  (rd_data_w[g]),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i[7:0]),
      .stat_wr_i  (stat_wr_i[g]),
      .stat_i     (stat_i),
      .err_i      (err_i),
      .buf_load_i (buf_load_i[g]),
      .buf_cnt_i  (buf_cnt_i),
      .dh_o       (dh_w[g]),
      .feat_o     (feat_o[8*g +: 8]),
      .rword_o    (rword_w[g]),
      .drq_o      (drq_w[g]),
      .ptr_o      (ptr_w[g]),
      .cmd_exec_o (cmd_exec_o[g]),
      .warn_o     (proto_warn_o[g]),
      .ctrl_wr_o  (ctrl_wr_o[g])
    );
  end

  assign buf_ptr_o = ptr_w[ans];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      no_dev_o <= 1'b0;
      dwr_o    <= 1'b0;
      dwdata_o <= '0;
      cmd_o    <= '0;
      ctrl_o   <= '0;
    end else begin
      rvalid_o <= rd_i;
      no_dev_o <= (rd_i | wr_i) & ~any_dev;
      dwr_o    <= 1'b0;
      if (rd_i) begin
        if (!any_dev)
          rdata_o <= '0;
        else if (addr_i == RA_DATA)
          rdata_o <= drq_w[ans] ? buf_rdata_i : 16'h0000;
        else
          rdata_o <= rword_w[ans];
      end
      if (wr_i && any_dev) begin
        unique case (addr_i)
          RA_STATCMD: cmd_o  <= wdata_i[7:0];
          RA_ALTCTL:  ctrl_o <= wdata_i[7:0];
          RA_DATA: begin
            dwr_o    <= 1'b1;
            dwdata_o <= wdata_i;
          end
          default: ;
        endcase
      end
    end
  end

  p_no_dev_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && dev_present_i == 2'b00) |=> no_dev_o);

  p_no_dev_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && dev_present_i == 2'b00) |=> (rdata_o == 16'h0000));

  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  p_status_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && any_dev && (addr_i == RA_STATCMD || addr_i == RA_ALTCTL)
      && dh_w[ans][DH_SEL] != ans) |=> (rdata_o == 16'h0000));

  p_lone_answer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_present_i == 2'b10) |-> ans);

  p_single_exec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_exec_o == 2'b11) |-> (cmd_o == OP_DIAG));
endmodule

// File: tb/ata_tf_host_tb_top.sv
module ata_tf_host_tb_top;
  localparam int CNT_W = 9;
  localparam int PTR_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       present = 2'b00;
  logic [3:0]       addr = '0;
  logic             wr = 1'b0, rd = 1'b0;
  logic [15:0]      wdata = '0;
  logic [15:0]      rdata;
  logic             rvalid, no_dev, dwr;
  logic [1:0]       stat_wr = '0, buf_load = '0;
  logic [7:0]       stat_v = '0, err_v = '0;
  logic [CNT_W-1:0] buf_cnt = '0;
  logic [PTR_W-1:0] buf_ptr;
  logic [15:0]      buf_rdata, dwdata, feat;
  logic [1:0]       cmd_exec, warn, ctrl_wr;
  logic [7:0]       cmd, ctrl;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  function automatic logic [15:0] word_of(input logic [7:0] p);
    return {p ^ 8'h5A, ~p};
  endfunction

  assign buf_rdata = word_of(buf_ptr);

  ata_tf_host #(.CNT_W(CNT_W), .PTR_W(PTR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dev_present_i(present), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .no_dev_o(no_dev), .stat_wr_i(stat_wr), .stat_i(stat_v), .err_i(err_v),
    .buf_load_i(buf_load), .buf_cnt_i(buf_cnt), .buf_ptr_o(buf_ptr),
    .buf_rdata_i(buf_rdata), .dwr_o(dwr), .dwdata_o(dwdata), .cmd_exec_o(cmd_exec),
    .cmd_o(cmd), .feat_o(feat), .proto_warn_o(warn), .ctrl_wr_o(ctrl_wr), .ctrl_o(ctrl)
  );

  // reference model
  logic [7:0] m_scnt[2], m_snum[2], m_cyll[2], m_cylh[2], m_feat[2], m_err[2];
  logic [7:0] m_dh[2], m_stat[2], m_ptr[2];
  bit         m_drq[2];
  int         m_wcnt[2];
  logic [15:0] e_rdata, e_dwdata;
  logic [7:0]  e_cmd, e_ctrl;
  bit          e_rvalid, e_nodev, e_dwr;
  bit [1:0]    e_exec, e_warn, e_ctrl_wr;
  string       rd_tag;

  function automatic int answer();
    if (present == 2'b11) return m_dh[1][4] ? 1 : 0;
    return present[1] && !present[0] ? 1 : 0;
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_scnt[d] = 0; m_snum[d] = 0; m_cyll[d] = 0; m_cylh[d] = 0; m_feat[d] = 0;
      m_err[d] = 0; m_dh[d] = 8'hA0; m_stat[d] = 0; m_ptr[d] = 0; m_drq[d] = 0; m_wcnt[d] = 0;
    end
    e_rdata = 0; e_dwdata = 0; e_cmd = 0; e_ctrl = 0;
    e_rvalid = 0; e_nodev = 0; e_dwr = 0; e_exec = 0; e_warn = 0; e_ctrl_wr = 0;
    rd_tag = "R11";
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int a;
      logic [7:0] w;
      a = answer();
      w = wdata[7:0];
      e_rvalid = rd; e_nodev = (rd || wr) && present == 2'b00;
      e_exec = 0; e_warn = 0; e_ctrl_wr = 0; e_dwr = 0;
      if (rd) begin
        if (present == 2'b00) begin e_rdata = 0; rd_tag = "R2"; end
        else case (addr)
          4'h0: if (m_drq[a]) begin
                  e_rdata = word_of(m_ptr[a]); rd_tag = "R6";
                  m_ptr[a] = m_ptr[a] + 1; m_wcnt[a] = m_wcnt[a] - 1;
                  if (m_wcnt[a] == 0) m_drq[a] = 0;
                end else begin e_rdata = 0; rd_tag = "R5"; end
          4'h1: begin e_rdata = {8'h0, m_err[a]}; rd_tag = "R3"; end
          4'h2: begin e_rdata = {8'h0, m_scnt[a]}; rd_tag = "R3"; end
          4'h3: begin e_rdata = {8'h0, m_snum[a]}; rd_tag = "R1"; end
          4'h4: begin e_rdata = {8'h0, m_cyll[a]}; rd_tag = "R1"; end
          4'h5: begin e_rdata = {8'h0, m_cylh[a]}; rd_tag = "R1"; end
          4'h6: begin e_rdata = {8'h0, m_dh[a]}; rd_tag = "R10"; end
          4'h7, 4'hE: begin
            rd_tag = "R4";
            e_rdata = (int'(m_dh[a][4]) == a) ? {8'h0, m_stat[a] | (m_drq[a] ? 8'h08 : 8'h00)} : 16'h0;
          end
          default: e_rdata = 0;
        endcase
      end
      if (wr && present != 2'b00) begin
        if (addr == 4'h7) e_cmd = w;
        if (addr == 4'hE) e_ctrl = w;
        if (addr == 4'h0) begin e_dwr = 1; e_dwdata = wdata; end
      end
      for (int d = 0; d < 2; d++) if (wr && present[d]) begin
        case (addr)
          4'h1: m_feat[d] = w;
          4'h2: m_scnt[d] = w;
          4'h3: m_snum[d] = w;
          4'h4: m_cyll[d] = w;
          4'h5: m_cylh[d] = w;
          4'h6: m_dh[d] = 8'hA0 | (w & 8'h1F);
          4'h7: begin
            e_warn[d] = (m_stat[d][7] || m_drq[d]) && w != 8'h08;
            e_exec[d] = (int'(m_dh[d][4]) == d) || w == 8'h90;
          end
          4'hE: e_ctrl_wr[d] = 1;
          default: ;
        endcase
      end
      for (int d = 0; d < 2; d++) begin
        if (buf_load[d]) begin
          m_wcnt[d] = int'(buf_cnt); m_ptr[d] = 0; m_drq[d] = buf_cnt != 0;
        end
        if (stat_wr[d]) begin
          m_stat[d] = stat_v & 8'hF7; m_err[d] = err_v;
          if (!stat_v[3]) m_drq[d] = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R11 rvalid", 32'(rvalid), 32'(e_rvalid));
      if (e_rvalid) chk({rd_tag, " rdata"}, 32'(rdata), 32'(e_rdata));
      chk("R2 no_dev", 32'(no_dev), 32'(e_nodev));
      chk("R7 exec", 32'(cmd_exec), 32'(e_exec));
      chk("R7 cmd", 32'(cmd), 32'(e_cmd));
      chk("R8 warn", 32'(warn), 32'(e_warn));
      chk("R9 ctrl_wr", 32'(ctrl_wr), 32'(e_ctrl_wr));
      chk("R9 ctrl", 32'(ctrl), 32'(e_ctrl));
      chk("R1 dwr", 32'(dwr), 32'(e_dwr));
      if (e_dwr) chk("R1 dwdata", 32'(dwdata), 32'(e_dwdata));
      chk("R1 feat", 32'(feat), {16'h0, m_feat[1], m_feat[0]});
      chk("R6 ptr", 32'(buf_ptr), 32'(m_ptr[answer()]));
    end
  end

  task automatic hw(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1; @(negedge clk); wr = 0;
  endtask
  task automatic hr(input logic [3:0] a);
    addr = a; rd = 1; @(negedge clk); rd = 0;
  endtask
  task automatic stw(input int d, input logic [7:0] s, input logic [7:0] e);
    stat_v = s; err_v = e; stat_wr[d] = 1; @(negedge clk); stat_wr = 0;
  endtask
  task automatic bload(input int d, input int n);
    buf_cnt = CNT_W'(n); buf_load[d] = 1; @(negedge clk); buf_load = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000ns;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 rvalid", 32'(rvalid), 0);
    chk("R12 exec", 32'(cmd_exec), 0);
    chk("R12 ctrl_wr", 32'(ctrl_wr), 0);
    chk("R12 rdata", 32'(rdata), 0);
    rst_n = 1;
    @(negedge clk);
    // R2: nothing present
    hw(4'h2, 16'h0005); hr(4'h2);
    // one device
    present = 2'b01;
    hr(4'h6); hr(4'h7);               // R12 device/head 0xA0, status 0
    stw(0, 8'h50, 8'h00);
    hw(4'h2, 16'h0012); hw(4'h3, 16'h0034); hw(4'h4, 16'h0056); hw(4'h5, 16'h0078);
    hw(4'h1, 16'h0077);
    hr(4'h2); hr(4'h3); hr(4'h4); hr(4'h5); hr(4'h7); hr(4'hE);
    hw(4'h6, 16'h00FF); hr(4'h6);     // R10 reads 0xBF
    hr(4'h7); hr(4'hE);               // R4 masked
    hw(4'h7, 16'h0020);               // R7 not selected
    hw(4'h7, 16'h0090);               // R7 diagnostics
    hw(4'h6, 16'h0003);
    // two devices
    present = 2'b11;
    hw(4'h6, 16'h0010);
    stw(1, 8'h41, 8'h04);
    hr(4'h7); hr(4'h1);               // R3 device 1 answers
    hw(4'h2, 16'h0099); hr(4'h2);
    hw(4'h6, 16'h0000); hr(4'h2); hr(4'h7);
    hw(4'h6, 16'h0010); hw(4'h7, 16'h00C8);
    hw(4'h6, 16'h0000); hw(4'h7, 16'h00C8);
    hw(4'h7, 16'h0090);
    // R8 busy warning
    stw(0, 8'hD0, 8'h00);
    hw(4'h7, 16'h0020); hw(4'h7, 16'h0008);
    stw(0, 8'h50, 8'h00);
    // R6 buffer drain
    bload(0, 3);
    hr(4'h7); hw(4'h7, 16'h0020);     // R8 via DRQ
    repeat (4) hr(4'h0);
    hr(4'h7);
    bload(1, 2);
    hw(4'h6, 16'h0010);
    hr(4'h0);
    stw(1, 8'h40, 8'h00);             // clears DRQ
    hr(4'h0);                         // R5
    bload(0, 0);
    hw(4'h6, 16'h0000); hr(4'h0); hr(4'h7);
    // R9 control and data-port writes
    hw(4'hE, 16'h0004); hw(4'hE, 16'h0000);
    hw(4'h0, 16'hBEEF);
    // lone device 1
    present = 2'b10;
    hr(4'h7); hr(4'h2);
    hw(4'h6, 16'h0010); hr(4'h7);
    hw(4'h7, 16'h00EC);
    // none present again
    present = 2'b00;
    hw(4'h7, 16'h0090); hr(4'h7);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule